// File: doc/BRIEF.md
# Single-Clock Ring FIFO with Selectable Read Latency

This block is a first-in first-out buffer for one clock domain. Words are stored in a register array used as a ring: a write position and a read position advance independently and wrap back to the first slot after the last one. Each producer strobe stores one word and each consumer strobe retires the oldest word. Two flags report a completely occupied and a completely vacant buffer.

A single parameter selects how the oldest word reaches the output, and the port list is the same in both modes. In fall-through mode the oldest word is on the output at all times while the buffer holds data, so a consumer can take it in the cycle it pops. In registered mode the retired word is captured on the clock edge that accepts the pop and stays on the output until the next accepted pop. The depth and the word width are parameters. The default is 32 words of 32 bits, and the depth does not have to be a power of two.

Top module: `ring_fifo`

## Requirements
- R1: While `rst_n` is low, `is_empty` is 1 and `is_full` is 0. In registered mode (`FALL_THROUGH` = 0), `pop_data` is all zeros during reset and stays zero until the first accepted pop.
- R2: Words leave the buffer in exactly the order they were accepted.
- R3: `is_full` is 1 exactly when DEPTH words are held, and `is_empty` is 1 exactly when none are held. The two flags are never 1 together.
- R4: A push while `is_full` is 1 is ignored, even when a pop is accepted in the same cycle. The stored words, their order and the flags are unchanged by the push.
- R5: A pop while `is_empty` is 1 is ignored, even when a push is accepted in the same cycle. The flags do not move because of the pop, and in registered mode `pop_data` holds its value.
- R6: A push and a pop in the same cycle, with the buffer neither full nor empty, are both accepted and the occupancy stays the same.
- R7: With `FALL_THROUGH` = 1, `pop_data` combinationally shows the oldest held word, so the word retired by a pop is on the output in the cycle the pop is asserted.
- R8: With `FALL_THROUGH` = 0, the word retired by an accepted pop appears on `pop_data` after the clock edge that accepts it. The output holds its value through cycles with no accepted pop.
- R9: The read and write positions wrap from slot DEPTH-1 to slot 0 for any depth, including depths that are not a power of two. A lap bit kept with each position tells a full buffer from an empty one when the two slots are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Store `push_data` this cycle if not full |
| push_data | input | WIDTH | Word to store |
| pop | input | 1 | Retire the oldest word this cycle if not empty |
| pop_data | output | WIDTH | Oldest word (fall-through) or last retired word (registered) |
| is_full | output | 1 | All DEPTH slots occupied |
| is_empty | output | 1 | No slot occupied |

## Verification
The bench runs a fall-through and a registered copy side by side at a depth of five, so the positions must wrap at a slot count that is not a power of two. A wrap written as a plain binary rollover shows up as words returned out of order and as flags that disagree with the reference occupancy. The bench pushes into a full buffer while popping, and pops an empty buffer while pushing. A design that lets the blocked strobe through overwrites the oldest word, returns stale data or moves a flag. Long runs of simultaneous push and pop at one held word catch an occupancy that drifts. Pops that are refused check that the registered output holds still and does not reload from the array.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

  // Address bits needed for a ring of the given depth (at least one).
  function automatic int unsigned ring_addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // True when a position sits on the last slot of the ring.
  function automatic bit ring_at_end(input int unsigned slot, input int unsigned depth);
    return slot == depth - 1;
  endfunction

  // Slot that follows the given one, wrapping to zero after the last.
  function automatic int unsigned ring_next(input int unsigned slot, input int unsigned depth);
    return ring_at_end(slot, depth) ? 0 : slot + 1;
  endfunction

  // Same slot, opposite lap: the writer is a whole ring ahead.
  function automatic bit ring_full(input int unsigned wslot, input bit wlap,
                                   input int unsigned rslot, input bit rlap);
    return (wslot == rslot) && (wlap != rlap);
  endfunction

  // Same slot, same lap: nothing between reader and writer.
  function automatic bit ring_empty(input int unsigned wslot, input bit wlap,
                                    input int unsigned rslot, input bit rlap);
    return (wslot == rslot) && (wlap == rlap);
  endfunction

endpackage

// File: rtl/ring_fifo_ptr.sv
module ring_fifo_ptr
  import ring_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = ring_addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_slot,
  output logic [AW-1:0] rd_slot,
  output logic          full,
  output logic          empty,
  output logic          wr_fire,
  output logic          rd_fire
);

  logic [AW-1:0] wslot_q, rslot_q;
  logic          wlap_q, rlap_q;

  assign full    = ring_full(32'(wslot_q), wlap_q, 32'(rslot_q), rlap_q);
  assign empty   = ring_empty(32'(wslot_q), wlap_q, 32'(rslot_q), rlap_q);
  assign wr_fire = push & ~full;
  assign rd_fire = pop & ~empty;
  assign wr_slot = wslot_q;
  assign rd_slot = rslot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wslot_q <= '0;
      wlap_q  <= 1'b0;
    end else if (wr_fire) begin
      wslot_q <= AW'(ring_next(32'(wslot_q), DEPTH));
      if (ring_at_end(32'(wslot_q), DEPTH)) wlap_q <= ~wlap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rslot_q <= '0;
      rlap_q  <= 1'b0;
    end else if (rd_fire) begin
      rslot_q <= AW'(ring_next(32'(rslot_q), DEPTH));
      if (ring_at_end(32'(rslot_q), DEPTH)) rlap_q <= ~rlap_q;
    end
  end

endmodule

// File: rtl/ring_fifo_store.sv
module ring_fifo_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] row_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) row_q[waddr] <= wdata;
  end

  assign rdata = row_q[raddr];

endmodule

// File: rtl/ring_fifo_rdout.sv
module ring_fifo_rdout #(
  parameter int unsigned WIDTH        = 32,
  parameter bit          FALL_THROUGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] head,
  output logic [WIDTH-1:0] dout
);

  generate
    if (FALL_THROUGH) begin : g_pass
      logic unused_regpath;
      assign unused_regpath = ^{clk, rst_n, load};
      assign dout = head;
    end else begin : g_reg
      logic [WIDTH-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_q <= '0;
        else if (load) out_q <= head;
      end
      assign dout = out_q;
    end
  endgenerate

endmodule

// File: rtl/ring_fifo.sv
module ring_fifo
  import ring_fifo_pkg::*;
#(
  parameter int unsigned DEPTH        = 32,
  parameter int unsigned WIDTH        = 32,
  parameter bit          FALL_THROUGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             is_full,
  output logic             is_empty
);

  localparam int unsigned AW = ring_addr_bits(DEPTH);

  // Named internal events, visible to the bound checker.
  logic          wr_fire;
  logic          rd_fire;
  logic [AW-1:0] wr_slot;
  logic [AW-1:0] rd_slot;
  logic [WIDTH-1:0] head_word;

  ring_fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .pop     (pop),
    .wr_slot (wr_slot),
    .rd_slot (rd_slot),
    .full    (is_full),
    .empty   (is_empty),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire)
  );

  ring_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_slot),
    .wdata (push_data),
    .raddr (rd_slot),
    .rdata (head_word)
  );

  ring_fifo_rdout #(.WIDTH(WIDTH), .FALL_THROUGH(FALL_THROUGH)) u_rdout (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_fire),
    .head  (head_word),
    .dout  (pop_data)
  );

endmodule

// File: rtl/ring_fifo_chk.sv
module ring_fifo_chk #(
  parameter int unsigned WIDTH        = 32,
  parameter bit          FALL_THROUGH = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             pop,
  input logic             is_full,
  input logic             is_empty,
  input logic             wr_fire,
  input logic             rd_fire,
  input logic [WIDTH-1:0] pop_data
);

  AST_RESET_FLAGS: assert property (@(posedge clk)
    !rst_n |-> (is_empty && !is_full)); // R1

  AST_RESET_OUTREG: assert property (@(posedge clk)
    (!rst_n && !FALL_THROUGH) |-> (pop_data == '0)); // R1

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_full && is_empty)); // R3

  AST_FULL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_full) |-> $past(wr_fire && !rd_fire)); // R3

  AST_EMPTY_ONLY_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_empty) |-> $past(rd_fire && !wr_fire)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && !pop) |=> is_full); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && !push) |=> is_empty); // R5

  AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> ($stable(is_full) && $stable(is_empty))); // R6

  AST_OUTREG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!FALL_THROUGH && !rd_fire) |=> $stable(pop_data)); // R8

endmodule

bind ring_fifo ring_fifo_chk #(.WIDTH(WIDTH), .FALL_THROUGH(FALL_THROUGH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push     (push),
  .pop      (pop),
  .is_full  (is_full),
  .is_empty (is_empty),
  .wr_fire  (wr_fire),
  .rd_fire  (rd_fire),
  .pop_data (pop_data)
);

// File: tb/ring_fifo_tb.sv
module ring_fifo_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 5;
  localparam int WIDTH      = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             push = 1'b0;
  logic             pop = 1'b0;
  logic [WIDTH-1:0] push_data = '0;
  logic [WIDTH-1:0] ft_data, rg_data;
  logic             ft_full, ft_empty, rg_full, rg_empty;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [WIDTH-1:0] model [$];
  logic [WIDTH-1:0] rg_last;
  logic [15:0]      lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .FALL_THROUGH(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(ft_data), .is_full(ft_full), .is_empty(ft_empty));

  ring_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .FALL_THROUGH(1'b0)) u_dut_reg (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(rg_data), .is_full(rg_full), .is_empty(rg_empty));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // One cycle: drive, check pre-edge outputs, advance the model, check post-edge.
  task automatic step(input bit p, input bit q, input logic [WIDTH-1:0] d, input string tag);
    bit wf, rf;
    logic [WIDTH-1:0] popped;
    int lvl;
    @(negedge clk);
    push = p; pop = q; push_data = d;
    #1;
    lvl = model.size();
    check(ft_full == (lvl == DEPTH) && rg_full == (lvl == DEPTH),
          {tag, " R3 full flag"}, {ft_full, rg_full}, {2{lvl == DEPTH}});
    check(ft_empty == (lvl == 0) && rg_empty == (lvl == 0),
          {tag, " R3 empty flag"}, {ft_empty, rg_empty}, {2{lvl == 0}});
    if (q && lvl > 0)
      check(ft_data == model[0], {tag, " R7 fall-through head"}, ft_data, model[0]);
    wf = p && (lvl < DEPTH);
    rf = q && (lvl > 0);
    popped = '0;
    if (rf) popped = model.pop_front();
    if (wf) model.push_back(d);
    @(posedge clk);
    #1;
    if (rf)
      check(rg_data == popped, {tag, " R2 R8 registered word"}, rg_data, popped);
    else
      check(rg_data == rg_last, {tag, " R8 R5 registered hold"}, rg_data, rg_last);
    rg_last = rg_data;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ft_empty && rg_empty, "R1 empty in reset", {ft_empty, rg_empty}, 2'b11);
    check(!ft_full && !rg_full, "R1 full clear in reset", {ft_full, rg_full}, 2'b00);
    check(rg_data == '0, "R1 registered output zero", rg_data, 0);
    rst_n = 1'b1;
    rg_last = '0;

    // Fill past full: the sixth push must be refused (R4).
    for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 1'b0, 8'h10 + 8'(i), "fill R4");
    // Push and pop together while full: only the pop is accepted (R4).
    step(1'b1, 1'b1, 8'hEE, "full both R4");
    check(model.size() == DEPTH - 1 && model[DEPTH-2] == 8'h14,
          "R4 blocked push not stored", model[DEPTH-2], 8'h14);
    step(1'b1, 1'b0, 8'h20, "refill");
    // Drain past empty: extra pops are refused (R5).
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, 8'h00, "drain R5");
    // Push and pop together while empty: only the push is accepted (R5).
    step(1'b1, 1'b1, 8'h33, "empty both R5");
    // Sustained push and pop at one word: occupancy fixed, slots wrap (R6, R9).
    for (int i = 0; i < 3 * DEPTH + 1; i++) step(1'b1, 1'b1, 8'h40 + 8'(i), "steady R6 R9");
    // Pseudo-random mix over many wraps (R2, R9).
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5], lfsr[15:8], "mix R2 R9");
    end
    for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 1'b1, 8'h00, "final drain R2");
    step(1'b0, 1'b0, 8'h00, "idle R8");
    summary();
    $finish;
  end

endmodule